// File: doc/BRIEF.md
# Staged Butterfly Byte Shuffle

This block reorders the bytes of two equal-width vectors through a chain of butterfly stages. A scalar control word drives the chain. Stage `i` works at the distance `2^i` bytes. When its control bit is set, the stage exchanges byte `k` of vector A with byte `k + 2^i` of vector B, for every index `k` whose bit `i` is clear. When its control bit is clear, the stage leaves both vectors alone. The stages run from the shortest distance to the longest.

Each stage has two named modes: PASS and SWAP. The stage's control bit selects the mode afresh on every cycle. There is no other state and no other transition. In the default pipelined build, each stage is one register slice, so a new pair of vectors can enter on every clock. A valid flag travels next to the data, and the result leaves after as many cycles as there are stages.

Operands are taken by value. A caller that shuffles a register with itself drives the same value on both inputs. The caller then writes the B result back to that register.

Top module: `byte_butterfly_shuffle`

## Requirements
- R1: While `rst_n` is low and during the first cycles after it rises, `out_valid` is 0 and both output vectors are all zero.
- R2: `out_valid` repeats `in_valid` exactly `STAGES` clock cycles later (7 with 128-byte vectors). Cycles with `in_valid` low produce no output.
- R3: Control bit `i` (bit 0 = least significant) enables the stage of distance `2^i`. The stages are applied in ascending order of distance, 1 up to 64.
- R4: In an enabled stage of distance `d`, for every byte index `k` whose bit at `d` is clear, the new A byte `k` is the old B byte `k+d`, and the new B byte `k+d` is the old A byte `k`. Byte `k` occupies bits `8k+7:8k` of a vector.
- R5: In a disabled stage, both vectors pass through unchanged.
- R6: A control word of zero returns both vectors unchanged.
- R7: Control bits above bit `STAGES-1` have no effect on the result.
- R8: When the same value is driven on both vector inputs, the result is the same as for two independent copies. The B output is the value to write back.
- R9: Vectors accepted on consecutive cycles are shuffled independently, each with its own control word.
- R10: Every stage preserves the XOR of all bytes of both vectors taken together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks an accepted operand pair |
| in_ctrl | input | CTRL_W (32) | Shuffle control word |
| in_vec_a | input | 8*VEC_BYTES (1024) | Operand vector A |
| in_vec_b | input | 8*VEC_BYTES (1024) | Operand vector B |
| out_valid | output | 1 | Marks a finished result pair |
| out_vec_a | output | 8*VEC_BYTES (1024) | Resulting vector A |
| out_vec_b | output | 8*VEC_BYTES (1024) | Resulting vector B |

## Verification
The hardest situation to reach from the ports is a full pipeline in which every stage holds a different operand pair with a different control word. A fault that leaks control bits or data between neighbouring slices only appears in that situation. The stimulus streams long runs of back-to-back random vectors with random control words, including words with noise in the upper bits. It mixes in idle gaps so that bubbles sit between live slices. A single-stage pass uses byte patterns in which every byte is unique, so any lane mistake shows. A self-shuffle with identical operands exercises the pass-by-value case.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
    // Operating mode of one butterfly slice
    typedef enum logic {
        STG_PASS = 1'b0,
        STG_SWAP = 1'b1
    } stage_mode_t;
endpackage

// File: rtl/bfly_stage.sv
module bfly_stage #(
    parameter int VEC_BYTES = 128,
    parameter int SEL_W     = 7,
    parameter int BIT       = 0,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   vld_i,
    input  logic [SEL_W-1:0]       sel_i,
    input  logic [8*VEC_BYTES-1:0] a_i,
    input  logic [8*VEC_BYTES-1:0] b_i,
    output logic                   vld_o,
    output logic [SEL_W-1:0]       sel_o,
    output logic [8*VEC_BYTES-1:0] a_o,
    output logic [8*VEC_BYTES-1:0] b_o
);
    import bfly_pkg::*;

    localparam int DIST = 1 << BIT;
    localparam int W    = 8 * VEC_BYTES;

    stage_mode_t      mode;
    logic             swap_en;
    logic [W-1:0]     nxt_a;
    logic [W-1:0]     nxt_b;

    always_comb begin
        mode = sel_i[BIT] ? STG_SWAP : STG_PASS;
    end

    always_comb begin
        unique case (mode)
            STG_SWAP: swap_en = 1'b1;
            STG_PASS: swap_en = 1'b0;
            default:  swap_en = 1'b0;
        endcase
    end

    // Lane crossbar: lower partner of each pair in A, upper partner in B
    for (genvar k = 0; k < VEC_BYTES; k++) begin : g_lane
        if ((k & DIST) == 0) begin : g_low
            assign nxt_a[8*k +: 8] = swap_en ? b_i[8*(k+DIST) +: 8] : a_i[8*k +: 8];
            assign nxt_b[8*k +: 8] = b_i[8*k +: 8];
        end else begin : g_high
            assign nxt_a[8*k +: 8] = a_i[8*k +: 8];
            assign nxt_b[8*k +: 8] = swap_en ? a_i[8*(k-DIST) +: 8] : b_i[8*k +: 8];
        end
    end

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_o <= 1'b0;
                sel_o <= '0;
                a_o   <= '0;
                b_o   <= '0;
            end else begin
                vld_o <= vld_i;
                sel_o <= sel_i;
                a_o   <= nxt_a;
                b_o   <= nxt_b;
            end
        end

        function automatic logic swap_ok(input logic [W-1:0] ain, input logic [W-1:0] bin,
                                         input logic [W-1:0] aout, input logic [W-1:0] bout);
            logic ok;
            ok = 1'b1;
            for (int k = 0; k < VEC_BYTES; k++) begin
                if ((k & DIST) == 0) begin
                    if (aout[8*k +: 8] != bin[8*(k+DIST) +: 8]) ok = 1'b0;
                    if (bout[8*(k+DIST) +: 8] != ain[8*k +: 8]) ok = 1'b0;
                    if (bout[8*k +: 8] != bin[8*k +: 8]) ok = 1'b0;
                end else begin
                    if (aout[8*k +: 8] != ain[8*k +: 8]) ok = 1'b0;
                end
            end
            return ok;
        endfunction

        function automatic logic [7:0] fold(input logic [W-1:0] v);
            logic [7:0] acc;
            acc = '0;
            for (int k = 0; k < VEC_BYTES; k++) acc ^= v[8*k +: 8];
            return acc;
        endfunction

        // R4
        swap_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_i && sel_i[BIT]) |=> swap_ok($past(a_i), $past(b_i), a_o, b_o));

        // R5
        pass_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_i && !sel_i[BIT]) |=> (a_o == $past(a_i)) && (b_o == $past(b_i)));

        // R10
        byte_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
            vld_i |=> ((fold(a_o) ^ fold(b_o)) == $past(fold(a_i) ^ fold(b_i))));
    end else begin : g_comb
        assign vld_o = vld_i;
        assign sel_o = sel_i;
        assign a_o   = nxt_a;
        assign b_o   = nxt_b;
    end
endmodule

// File: rtl/byte_butterfly_shuffle.sv
module byte_butterfly_shuffle #(
    parameter int VEC_BYTES = 128,
    parameter int CTRL_W    = 32,
    parameter bit PIPELINED = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [CTRL_W-1:0]      in_ctrl,
    input  logic [8*VEC_BYTES-1:0] in_vec_a,
    input  logic [8*VEC_BYTES-1:0] in_vec_b,
    output logic                   out_valid,
    output logic [8*VEC_BYTES-1:0] out_vec_a,
    output logic [8*VEC_BYTES-1:0] out_vec_b
);
    localparam int STAGES = $clog2(VEC_BYTES);
    localparam int W      = 8 * VEC_BYTES;
    localparam int CNT_W  = $clog2(STAGES + 2) + 1;

    logic              vld_chain [STAGES+1];
    logic [STAGES-1:0] sel_chain [STAGES+1];
    logic [W-1:0]      a_chain   [STAGES+1];
    logic [W-1:0]      b_chain   [STAGES+1];

    logic ctrl_hi_unused;
    logic sel_tail_unused;

    // Only the low STAGES bits reach the network
    assign ctrl_hi_unused = ^in_ctrl[CTRL_W-1:STAGES];

    assign vld_chain[0] = in_valid;
    assign sel_chain[0] = in_ctrl[STAGES-1:0];
    assign a_chain[0]   = in_vec_a;
    assign b_chain[0]   = in_vec_b;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        bfly_stage #(
            .VEC_BYTES (VEC_BYTES),
            .SEL_W     (STAGES),
            .BIT       (s),
            .REGISTERED(PIPELINED)
        ) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .vld_i(vld_chain[s]),
            .sel_i(sel_chain[s]),
            .a_i  (a_chain[s]),
            .b_i  (b_chain[s]),
            .vld_o(vld_chain[s+1]),
            .sel_o(sel_chain[s+1]),
            .a_o  (a_chain[s+1]),
            .b_o  (b_chain[s+1])
        );
    end

    assign sel_tail_unused = ^sel_chain[STAGES];
    assign out_valid = vld_chain[STAGES];
    assign out_vec_a = a_chain[STAGES];
    assign out_vec_b = b_chain[STAGES];

    if (PIPELINED) begin : g_flight
        logic [CNT_W-1:0] in_flight;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                in_flight <= '0;
            end else begin
                in_flight <= in_flight + CNT_W'(in_valid) - CNT_W'(out_valid);
            end
        end

        // R2
        flight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_flight <= CNT_W'(STAGES));

        // R2
        no_orphan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (in_flight != '0));
    end
endmodule

// File: tb/byte_butterfly_shuffle_bench.sv
module byte_butterfly_shuffle_bench;
    localparam int CLK_PERIOD = 10;
    localparam int VB   = 128;
    localparam int W    = 8 * VB;
    localparam int LAT  = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_ctrl = '0;
    logic [W-1:0] in_vec_a = '0;
    logic [W-1:0] in_vec_b = '0;
    logic         out_valid;
    logic [W-1:0] out_vec_a;
    logic [W-1:0] out_vec_b;

    int n_checks = 0;
    int n_fails  = 0;

    bit           vq [$];
    logic [W-1:0] aq [$];
    logic [W-1:0] bq [$];
    string        rq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_butterfly_shuffle u_byte_butterfly_shuffle (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
        .in_vec_a(in_vec_a), .in_vec_b(in_vec_b), .out_valid(out_valid),
        .out_vec_a(out_vec_a), .out_vec_b(out_vec_b)
    );

    task automatic chk(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: byte arrays, swaps by distance
    function automatic void model(input logic [W-1:0] ai, input logic [W-1:0] bi,
                                  input logic [31:0] c,
                                  output logic [W-1:0] ao, output logic [W-1:0] bo);
        logic [7:0] va [VB];
        logic [7:0] vb [VB];
        logic [7:0] t;
        for (int k = 0; k < VB; k++) begin
            va[k] = ai[8*k +: 8];
            vb[k] = bi[8*k +: 8];
        end
        for (int d = 1; d < VB; d = d * 2) begin
            if ((c & d) != 0) begin
                for (int k = 0; k < VB; k++) begin
                    if ((k & d) == 0) begin
                        t = va[k];
                        va[k] = vb[k+d];
                        vb[k+d] = t;
                    end
                end
            end
        end
        for (int k = 0; k < VB; k++) begin
            ao[8*k +: 8] = va[k];
            bo[8*k +: 8] = vb[k];
        end
    endfunction

    function automatic logic [W-1:0] rand_vec();
        logic [W-1:0] v;
        for (int i = 0; i < W/32; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    // One clock: compare the oldest expectation, then drive and record a new one
    task automatic cycle(input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [31:0] c, input string req);
        bit ev; logic [W-1:0] ea, eb; string er;
        @(negedge clk);
        if (vq.size() >= LAT) begin
            ev = vq.pop_front(); ea = aq.pop_front(); eb = bq.pop_front(); er = rq.pop_front();
            chk(ev ? er : "R2", "out_valid", W'(out_valid), W'(ev));
            if (ev) begin
                if (er != "R8") chk(er, "out_vec_a", out_vec_a, ea);
                chk(er, "out_vec_b", out_vec_b, eb);
            end
        end
        in_valid = v; in_ctrl = c; in_vec_a = a; in_vec_b = b;
        model(a, b, c, ea, eb);
        vq.push_back(v); aq.push_back(ea); bq.push_back(eb); rq.push_back(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [W-1:0] pa, pb, sp;
        int n;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", W'(out_valid), W'(0));
        chk("R1", "out_vec_a in reset", out_vec_a, '0);
        chk("R1", "out_vec_b in reset", out_vec_b, '0);
        rst_n = 1'b1;
        for (int i = 0; i < LAT; i++) begin
            vq.push_back(1'b0); aq.push_back('0); bq.push_back('0); rq.push_back("R1");
        end
        @(posedge clk);
        chk("R1", "out_valid after reset", W'(out_valid), W'(0));
        chk("R1", "out_vec_a after reset", out_vec_a, '0);

        // R6: zero control
        for (int i = 0; i < 3; i++) cycle(1'b1, rand_vec(), rand_vec(), 32'h0, "R6");

        // R3 / R4: one stage at a time with unique bytes
        for (int k = 0; k < VB; k++) begin
            pa[8*k +: 8] = 8'(k);
            pb[8*k +: 8] = 8'(k) | 8'h80;
        end
        for (int i = 0; i < LAT; i++) cycle(1'b1, pa, pb, 32'(1) << i, "R3");
        for (int i = 0; i < 4; i++) cycle(1'b1, pa, pb, 32'($urandom_range(1, 127)), "R4");

        // R5: mixed enabled/disabled stages
        cycle(1'b1, rand_vec(), rand_vec(), 32'h55, "R5");
        cycle(1'b1, rand_vec(), rand_vec(), 32'h2a, "R5");

        // R7: noise above the stage bits
        cycle(1'b1, pa, pb, 32'hFFFF_FF80, "R7");
        for (int i = 0; i < 4; i++)
            cycle(1'b1, rand_vec(), rand_vec(), $urandom | 32'hABCD_0000, "R7");

        // R8: identical operands
        for (int i = 0; i < W/32; i++) sp[32*i +: 32] = 32'h089b_e55c;
        cycle(1'b1, sp, sp, 32'h454f_a926, "R8");
        sp = rand_vec();
        cycle(1'b1, sp, sp, $urandom, "R8");

        // R9: back-to-back stream; R2: bubbles mixed in
        for (int i = 0; i < 40; i++) cycle(1'b1, rand_vec(), rand_vec(), $urandom, "R9");
        for (int i = 0; i < 30; i++)
            cycle(($urandom % 3) != 0, rand_vec(), rand_vec(), $urandom, "R2");
        for (int i = 0; i < LAT; i++) cycle(1'b0, rand_vec(), rand_vec(), 32'h0, "R2");

        // R2 / R4: explicit latency and lane values for the widest stage
        cycle(1'b1, pa, pb, 32'h40, "R4");
        n = 0;
        do begin
            cycle(1'b0, '0, '0, 32'h0, "R2");
            n++;
        end while (!out_valid && n < 20);
        chk("R2", "latency", W'(n), W'(LAT));
        chk("R4", "A byte 0", W'(out_vec_a[7:0]), W'(8'hC0));
        chk("R4", "B byte 64", W'(out_vec_b[8*64 +: 8]), W'(8'h00));
        chk("R4", "A byte 64", W'(out_vec_a[8*64 +: 8]), W'(8'h40));
        for (int i = 0; i < LAT; i++) cycle(1'b0, '0, '0, 32'h0, "R2");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule